// File: doc/BRIEF.md
# Video Raster Geometry Meter

This block measures the geometry of an incoming video raster. On every sample strobe it looks at three timing flags: horizontal blanking, vertical blanking and field. From them it derives four counts: samples per line, active (unblanked) samples per line, lines per frame and active lines per frame. The flags come from one of two places. They can be decoded from the timing reference words embedded in the 10-bit sample stream, or they can be taken directly from three input pins. A select input picks the source.

Each count is first held in a shadow register as soon as its measurement completes. Once per frame, at the end of line 12, all four shadows are copied together into the host-visible registers. A host therefore never sees a mix of values from different frames. The host reads them through a 2-bit address and a 12-bit data port.

Top module: `raster_meter`

## Requirements
- R1: After reset, all four host registers read 0.
- R2: The read port returns total samples per line at address 0, active samples per line at 1, total lines per frame at 2 and active lines per frame at 3. The read is combinational.
- R3: A line starts on the first strobed sample whose H flag is 1 after a sample with H at 0. The samples-per-line value is the number of strobed samples from one line start up to the next, not counting the second line start.
- R4: The active-samples value counts the strobed samples of a line whose H flag is 0. In embedded-timing mode the four words of the closing reference sequence are excluded.
- R5: The frame starts at the first line start at which the field flag falls from 1 to 0, or at the first line start after such a fall if the fall happens in the middle of a line. That line is line 1.
- R6: The lines-per-frame value is the number of lines between two frame starts. A line is active when V is 0 on its first sample. The active-lines value counts those lines in the frame.
- R7: The host registers change only at the line start that ends line 12. All four change together. The sample counts they receive are those of line 12 itself.
- R8: The two line counts are published as 0 until a complete frame, bounded by two frame starts, has been measured.
- R9: In embedded-timing mode, a reference sequence is the words 3FF, 000, 000 followed by a flag word. The flag word carries F in bit 8, V in bit 7 and H in bit 6. The decoded flags apply from the next strobed sample onward.
- R10: With src_direct = 1, the flags come from h_in, v_in and f_in. With src_direct = 0, those pins are ignored.
- R11: Each count saturates at 4095 rather than wrapping.
- R12: Cycles with smp_en = 0 have no effect on any measurement, whatever the flags and data are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_en | input | 1 | Sample strobe; one video sample per high cycle |
| src_direct | input | 1 | 1: flags from pins, 0: flags decoded from vid_data |
| vid_data | input | 10 | Video sample word |
| h_in | input | 1 | Direct horizontal blanking flag |
| v_in | input | 1 | Direct vertical blanking flag |
| f_in | input | 1 | Direct field flag |
| rd_addr | input | 2 | Host register select |
| rd_data | output | 12 | Selected host register |

## Verification
At the line start that closes line 12, two things happen in the same cycle: line 12's sample counts are captured, and the host registers are committed. The bench provokes this with a frame in which line 11 and line 12 have clearly different widths (60/10 against 44/32). It then requires the published values to be 44/32, not the line 11 figures. It also reads the registers after line 12 has been sent but before line 13 starts, and requires the previous frame's values there, so that a commit one line early or late is also caught.

// File: rtl/raster_meter.sv
module raster_meter #(
  parameter int CW          = 12,
  parameter int DW          = 10,
  parameter int COMMIT_LINE = 12,
  parameter int EAV_WORDS   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_en,
  input  logic          src_direct,
  input  logic [DW-1:0] vid_data,
  input  logic          h_in,
  input  logic          v_in,
  input  logic          f_in,
  input  logic [1:0]    rd_addr,
  output logic [CW-1:0] rd_data
);
  localparam logic [CW-1:0] ONE    = {{(CW-1){1'b0}}, 1'b1};
  localparam logic [CW-1:0] CLINE  = CW'(COMMIT_LINE);
  localparam logic [CW-1:0] EAVN   = CW'(EAV_WORDS);
  localparam logic [DW-1:0] W_ONES = {DW{1'b1}};
  localparam int FB = DW - 2;
  localparam int VB = DW - 3;
  localparam int HB = DW - 4;

  function automatic logic [CW-1:0] sinc(input logic [CW-1:0] x);
    return (&x) ? x : x + ONE;
  endfunction

  // embedded reference decode
  logic [1:0] seq_st;
  logic       trs_h, trs_v, trs_f;
  wire        w_ones = (vid_data == W_ONES);
  wire        w_zero = (vid_data == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq_st <= 2'd0;
      trs_h  <= 1'b1;
      trs_v  <= 1'b1;
      trs_f  <= 1'b0;
    end else if (smp_en) begin
      if (seq_st == 2'd3) begin
        seq_st <= 2'd0;
        trs_f  <= vid_data[FB];
        trs_v  <= vid_data[VB];
        trs_h  <= vid_data[HB];
      end else if (w_ones) seq_st <= 2'd1;
      else if (seq_st != 2'd0 && w_zero) seq_st <= seq_st + 2'd1;
      else seq_st <= 2'd0;
    end
  end

  // effective flags and events
  wire eff_h = src_direct ? h_in : trs_h;
  wire eff_v = src_direct ? v_in : trs_v;
  wire eff_f = src_direct ? f_in : trs_f;

  logic prev_h, prev_f, f_pend, frame_seen;
  wire  boundary    = eff_h & ~prev_h;
  wire  f_fall      = prev_f & ~eff_f;
  wire  frame_start = boundary & (f_fall | f_pend);

  logic [CW-1:0] smp_cnt, act_cnt, line_no, al_cnt;
  logic [CW-1:0] sh_tl, sh_al;
  logic [CW-1:0] hr_ts, hr_as, hr_tl, hr_al;

  wire [CW-1:0] act_meas = src_direct ? act_cnt :
                           (act_cnt >= EAVN) ? act_cnt - EAVN : '0;
  wire commit = smp_en & boundary & frame_seen & (line_no == CLINE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_h     <= 1'b1;
      prev_f     <= 1'b0;
      f_pend     <= 1'b0;
      frame_seen <= 1'b0;
      smp_cnt    <= '0;
      act_cnt    <= '0;
      line_no    <= '0;
      al_cnt     <= '0;
      sh_tl      <= '0;
      sh_al      <= '0;
    end else if (smp_en) begin
      prev_h  <= eff_h;
      prev_f  <= eff_f;
      f_pend  <= boundary ? 1'b0 : (f_pend | f_fall);
      smp_cnt <= boundary ? ONE : sinc(smp_cnt);
      if (boundary) act_cnt <= '0;
      else if (!eff_h) act_cnt <= sinc(act_cnt);
      if (frame_start) begin
        line_no    <= ONE;
        al_cnt     <= eff_v ? '0 : ONE;
        frame_seen <= 1'b1;
        if (frame_seen) begin
          sh_tl <= line_no;
          sh_al <= al_cnt;
        end
      end else if (boundary) begin
        line_no <= sinc(line_no);
        if (!eff_v) al_cnt <= sinc(al_cnt);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hr_ts <= '0;
      hr_as <= '0;
      hr_tl <= '0;
      hr_al <= '0;
    end else if (commit) begin
      hr_ts <= smp_cnt;
      hr_as <= act_meas;
      hr_tl <= sh_tl;
      hr_al <= sh_al;
    end
  end

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = hr_ts;
      2'd1:    rd_data = hr_as;
      2'd2:    rd_data = hr_tl;
      default: rd_data = hr_al;
    endcase
  end

  // R7: host registers move only on a commit
  p_host_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(hr_ts) && $stable(hr_as) && $stable(hr_tl) && $stable(hr_al));

  // R5: a frame start makes the next line number 1
  p_frame_line1_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_en && frame_start) |=> line_no == ONE);

  // R12: idle cycles leave the counters alone
  p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_en |=> $stable(smp_cnt) && $stable(act_cnt) && $stable(line_no) && $stable(al_cnt));

  // R4: active samples never exceed the samples of the same line
  p_act_le_tot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    act_cnt <= smp_cnt);

  // R11: a saturated sample count stays saturated within the line
  p_sat_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_en && !boundary && (&smp_cnt)) |=> (&smp_cnt));
endmodule

// File: tb/raster_meter_tb.sv
`timescale 1ns/100ps
module raster_meter_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       smp_en = 1'b0;
  logic       src_direct = 1'b1;
  logic [9:0] vid_data = '0;
  logic       h_in = 1'b1, v_in = 1'b1, f_in = 1'b0;
  logic [1:0] rd_addr = '0;
  logic [11:0] rd_data;

  int total = 0, bad = 0, cyc = 0, gap = 0;
  int held_ts = 0, held_as = 0, held_tl = 0, held_al = 0;

  always #2 clk = ~clk;

  raster_meter u_dut (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .src_direct(src_direct),
    .vid_data(vid_data), .h_in(h_in), .v_in(v_in), .f_in(f_in),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // R2: address map 0 ts, 1 as, 2 tl, 3 al
  task automatic read_all(input string ctx, input int ets, input int eas,
                          input int etl, input int eal);
    @(negedge clk);
    smp_en = 1'b0;
    for (int a = 0; a < 4; a++) begin
      rd_addr = a[1:0];
      #0.4;
      case (a)
        0: chk({ctx, " R2 R3 total samples"}, rd_data, ets);
        1: chk({ctx, " R2 R4 active samples"}, rd_data, eas);
        2: chk({ctx, " R2 R6 total lines"}, rd_data, etl);
        default: chk({ctx, " R2 R6 active lines"}, rd_data, eal);
      endcase
    end
  endtask

  task automatic drive(input bit h, input bit v, input bit f, input logic [9:0] d);
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      smp_en = 1'b0; h_in = ~h; v_in = ~v; f_in = ~f; vid_data = 10'h3FF;
    end
    @(negedge clk);
    smp_en = 1'b1;
    if (src_direct) begin h_in = h; v_in = v; f_in = f; end
    else begin h_in = ~h_in; v_in = ~v_in; f_in = ~f_in; end
    vid_data = d;
  endtask

  task automatic dline(input int tot, input int act, input bit v, input bit f1, input bit f2);
    for (int i = 0; i < tot; i++)
      drive(i < tot - act, v, (i < tot / 2) ? f1 : f2, 10'h000);
  endtask

  task automatic tline(input int nb, input int na, input bit v, input bit f);
    logic [9:0] xe, xs;
    xe = {1'b1, f, v, 1'b1, 6'b0};
    xs = {1'b1, f, v, 1'b0, 6'b0};
    drive(0, 0, 0, 10'h3FF); drive(0, 0, 0, 10'h000); drive(0, 0, 0, 10'h000); drive(0, 0, 0, xe);
    for (int i = 0; i < nb; i++) drive(0, 0, 0, 10'h040);
    drive(0, 0, 0, 10'h3FF); drive(0, 0, 0, 10'h000); drive(0, 0, 0, 10'h000); drive(0, 0, 0, xs);
    for (int i = 0; i < na; i++) drive(0, 0, 0, 10'h200);
  endtask

  // direct frame: line sl1/sl2 may carry their own widths; last line field may fall mid-line
  task automatic dframe(input string ctx, input int n, input int vtop, input int vbot,
                        input int tot, input int act,
                        input int sl1, input int st1, input int sa1,
                        input int sl2, input int st2, input int sa2,
                        input bit split_end,
                        input int ets, input int eas, input int etl, input int eal);
    for (int l = 1; l <= n; l++) begin
      int t, a;
      bit v, last;
      t = (l == sl1) ? st1 : (l == sl2) ? st2 : tot;
      a = (l == sl1) ? sa1 : (l == sl2) ? sa2 : act;
      v = (l <= vtop) || (l > n - vbot);
      last = (l == n);
      dline(t, a, v, last, last && !split_end);
      if (l == 12) read_all({ctx, " R7 before line 13"}, held_ts, held_as, held_tl, held_al);
      if (l == 13) begin
        read_all({ctx, " R7 after line 12"}, ets, eas, etl, eal);
        held_ts = ets; held_as = eas; held_tl = etl; held_al = eal;
      end
    end
  endtask

  task automatic tframe(input string ctx, input int n, input int vtop, input int vbot,
                        input int nb, input int na,
                        input int ets, input int eas, input int etl, input int eal);
    for (int l = 1; l <= n; l++) begin
      tline(nb, na, (l <= vtop) || (l > n - vbot), l == n);
      if (l == 12) read_all({ctx, " R9 R7 before line 13"}, held_ts, held_as, held_tl, held_al);
      if (l == 13) begin
        read_all({ctx, " R9 R10 after line 12"}, ets, eas, etl, eal);
        held_ts = ets; held_as = eas; held_tl = etl; held_al = eal;
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; smp_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    held_ts = 0; held_as = 0; held_tl = 0; held_al = 0;
  endtask

  task automatic test_reset();
    read_all("R1 reset", 0, 0, 0, 0);
  endtask

  // R3 R4 R6 R8: first frame publishes zero line counts, second the real ones
  task automatic test_direct_basic();
    dline(40, 30, 1, 1, 1);
    dframe("R8 frame1", 20, 3, 2, 40, 30, 0, 0, 0, 0, 0, 0, 0, 40, 30, 0, 0);
    dframe("R6 frame2", 20, 3, 2, 40, 30, 0, 0, 0, 0, 0, 0, 0, 40, 30, 20, 15);
  endtask

  // R7: line 12 capture and commit in one cycle; line 11 differs
  task automatic test_commit_collision();
    dframe("R7 collide", 20, 3, 2, 40, 30, 11, 60, 10, 12, 44, 32, 1, 44, 32, 20, 15);
  endtask

  // R5: field fell mid-line at end of previous frame; next line is line 1
  task automatic test_midline_field();
    dframe("R5 midfall", 16, 2, 1, 40, 30, 0, 0, 0, 0, 0, 0, 0, 40, 30, 20, 15);
    dframe("R5 after", 16, 2, 1, 40, 30, 0, 0, 0, 0, 0, 0, 0, 40, 30, 16, 13);
  endtask

  // R12: idle cycles with flipped flags in between every sample
  task automatic test_gaps();
    gap = 2;
    dframe("R12 gaps", 16, 2, 1, 36, 24, 0, 0, 0, 0, 0, 0, 0, 36, 24, 16, 13);
    gap = 0;
  endtask

  // R11: over-long line saturates both sample counts
  task automatic test_saturation();
    dframe("R11 sat", 16, 2, 1, 36, 24, 12, 5000, 4500, 0, 0, 0, 0, 4095, 4095, 16, 13);
  endtask

  // R9 R10 R4: embedded timing, direct pins toggled as noise
  task automatic test_trs();
    do_reset();
    read_all("R1 second reset", 0, 0, 0, 0);
    src_direct = 1'b0;
    tline(10, 20, 1, 1);
    tframe("R9 R8 trsA", 14, 2, 1, 10, 20, 38, 20, 0, 0);
    tframe("R9 R6 trsB", 14, 2, 1, 10, 20, 38, 20, 14, 11);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    test_direct_basic();
    test_commit_collision();
    test_midline_field();
    test_gaps();
    test_saturation();
    test_trs();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule